// File: doc/BRIEF.md
# BCD Calendar Update and Alarm Engine

This block keeps a calendar (seconds, minutes, hours, weekday, day of month, month and two-digit year) in internal binary counters. It steps the calendar forward once for each accepted 1 Hz tick. After each step it copies the new time into host-visible byte registers, which can be in BCD or in binary and in 12-hour or 24-hour form. The copy happens after a fixed delay, counted in microsecond ticks. An update-in-progress bit covers the gap between the step and the copy. At the end of each update the block compares the time against a three-byte alarm, in which any byte can be a wildcard. It then raises the alarm and update-ended flags.

The surrounding register interface supplies the control fields as static inputs. It writes a new time through a one-cycle load path, and it pulses a clear when software reads the flag byte. The oscillator-select field must hold the run setting (binary 010) for time to advance.

Top module: `rtc_calendar_engine`

## Requirements
- R1: A 1 Hz tick is ignored (no calendar step, no update bit) unless `osc_sel` equals 3'b010.
- R2: An accepted tick steps the internal calendar at that clock edge and sets `uip` at the same edge, unless set mode is on. On the `DELAY_US`-th following `us_tick`, the visible registers are refreshed from the calendar and `uip` is cleared at that same edge.
- R3: While `set_mode` is high, `uip` is not raised (and is cleared if high), the visible registers are not refreshed and no update-ended flag is raised. The internal calendar still advances.
- R4: Each visible field is BCD (tens in bits 7:4, units in bits 3:0) when `bin_mode` is 0, and plain binary when `bin_mode` is 1.
- R5: With `hr24` = 0, the hour byte holds the hour modulo 12, with 0 shown as 12 and bit 7 set for hours 12..23. With `hr24` = 1, it holds the hour 0..23.
- R6: Seconds and minutes wrap 59→0, hours 23→0, weekday 6→0, month 12→1 with the year incrementing, and year 99→0. The day of month returns to 1 after the month's last day.
- R7: February has 29 days when the full year (`CENTURY`*100 + two-digit year) is divisible by 4 and is not a century year that is indivisible by 400. Otherwise it has 28.
- R8: With `alarm_en` high, an update whose new time matches all three alarm bytes ORs 8'hA0 into `flags`. Each byte matches if it equals the current field in the active format or if its bits 7:6 are both 1. The hour alarm byte is decoded with the 12-hour rule of R5.
- R9: With `uend_en` high and set mode off, every completed update ORs 8'h90 into `flags`.
- R10: `flag_clr` clears `flags` at the next edge. If a flag is raised in the same cycle as the clear, the flag is kept.
- R11: `load_en` decodes the seven load bytes (in the active format, including the 12-hour PM bit) into the calendar in one cycle. It shows them at once in the visible registers, abandons any update in flight and clears `uip`.
- R12: After reset the calendar reads 00:00:00, weekday 0, day 1, month 1, year 0, with `uip` low and `flags` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle 1 Hz pulse |
| us_tick | input | 1 | One-cycle microsecond pulse |
| osc_sel | input | 3 | Oscillator select; 3'b010 = run |
| set_mode | input | 1 | Freeze visible registers and suppress update flags |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| alarm_en | input | 1 | Enable alarm flag |
| uend_en | input | 1 | Enable update-ended flag |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| load_en | input | 1 | Load the calendar from the load bytes |
| ld_sec | input | 8 | Load seconds |
| ld_min | input | 8 | Load minutes |
| ld_hr | input | 8 | Load hours |
| ld_wday | input | 8 | Load weekday (0..6) |
| ld_mday | input | 8 | Load day of month |
| ld_mon | input | 8 | Load month (1..12) |
| ld_year | input | 8 | Load two-digit year |
| flag_clr | input | 1 | Clear the flag byte |
| out_sec | output | 8 | Visible seconds |
| out_min | output | 8 | Visible minutes |
| out_hr | output | 8 | Visible hours |
| out_wday | output | 8 | Visible weekday |
| out_mday | output | 8 | Visible day of month |
| out_mon | output | 8 | Visible month |
| out_year | output | 8 | Visible year |
| uip | output | 1 | Update in progress |
| flags | output | 8 | Bit 7 any, bit 5 alarm, bit 4 update-ended |

## Verification
The `uip` bit is due one edge after the tick cycle. The refreshed fields and `flags` are due on the `DELAY_US`-th edge after the tick edge when `us_tick` is held high. A load is visible one edge after `load_en`, and a clear one edge after `flag_clr`. The bench drives `us_tick` continuously with `DELAY_US` = 4. It samples `uip` at the falling edge after the tick edge, and samples fields and flags `DELAY_US` + 2 falling edges later, once the copy has certainly taken place. It sweeps all 24 hours in 12-hour BCD, every month end, and three leap-year cases, and it tests the divider, set mode, alarm wildcards and cancellation of an update in flight, each against a calendar model kept in the bench.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] mday;
    logic [7:0] wday;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } vis_t;

  localparam logic [2:0] OSC_RUN   = 3'b010;
  localparam logic [7:0] FLG_ALARM = 8'hA0;
  localparam logic [7:0] FLG_UEND  = 8'h90;

  // binary value (0..99) to register byte
  function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
    logic [6:0] t;
    logic [6:0] u;
    t = v / 7'd10;
    u = v - t * 7'd10;
    return bin ? {1'b0, v} : {t[3:0], u[3:0]};
  endfunction

  // register byte to binary value
  function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : (7'(b[7:4]) * 7'd10 + 7'(b[3:0]));
  endfunction

  function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                          input logic h24);
    logic [4:0] h12;
    if (h24) return enc_val({2'b00, h}, bin);
    h12 = (h >= 5'd12) ? h - 5'd12 : h;
    if (h12 == 5'd0) h12 = 5'd12;
    return enc_val({2'b00, h12}, bin) | ((h >= 5'd12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin,
                                          input logic h24);
    logic [6:0] v;
    v = dec_val({1'b0, b[6:0]}, bin);
    if (h24) return v[4:0];
    if (v == 7'd12) v = 7'd0;
    if (b[7]) v = v + 7'd12;
    return v[4:0];
  endfunction

  function automatic logic is_leap(input int unsigned y);
    return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] yy,
                                           input int unsigned century);
    case (m)
      4'd2:                     return is_leap(century * 100 + 32'(yy)) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction

  function automatic cal_t next_sec(input cal_t c, input int unsigned century);
    cal_t n;
    n = c;
    if (c.sec != 6'd59) n.sec = c.sec + 6'd1;
    else begin
      n.sec = 6'd0;
      if (c.min != 6'd59) n.min = c.min + 6'd1;
      else begin
        n.min = 6'd0;
        if (c.hr != 5'd23) n.hr = c.hr + 5'd1;
        else begin
          n.hr   = 5'd0;
          n.wday = (c.wday >= 3'd6) ? 3'd0 : c.wday + 3'd1;
          if (c.mday >= month_len(c.mon, c.yr, century)) begin
            n.mday = 5'd1;
            if (c.mon >= 4'd12) begin
              n.mon = 4'd1;
              n.yr  = (c.yr >= 7'd99) ? 7'd0 : c.yr + 7'd1;
            end else begin
              n.mon = c.mon + 4'd1;
            end
          end else begin
            n.mday = c.mday + 5'd1;
          end
        end
      end
    end
    return n;
  endfunction

  function automatic vis_t fmt_cal(input cal_t c, input logic bin, input logic h24);
    vis_t v;
    v.sec  = enc_val({1'b0, c.sec}, bin);
    v.min  = enc_val({1'b0, c.min}, bin);
    v.hr   = enc_hour(c.hr, bin, h24);
    v.wday = enc_val({4'd0, c.wday}, bin);
    v.mday = enc_val({2'd0, c.mday}, bin);
    v.mon  = enc_val({3'd0, c.mon}, bin);
    v.yr   = enc_val(c.yr, bin);
    return v;
  endfunction

  function automatic cal_t dec_cal(input vis_t r, input logic bin, input logic h24);
    cal_t c;
    logic [6:0] s, m, w, d, mo, y;
    s  = dec_val(r.sec, bin);
    m  = dec_val(r.min, bin);
    w  = dec_val(r.wday, bin);
    d  = dec_val(r.mday, bin);
    mo = dec_val(r.mon, bin);
    y  = dec_val(r.yr, bin);
    c.sec  = s[5:0];
    c.min  = m[5:0];
    c.hr   = dec_hour(r.hr, bin, h24);
    c.wday = w[2:0];
    c.mday = d[4:0];
    c.mon  = mo[3:0];
    c.yr   = y;
    return c;
  endfunction

endpackage

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
  import rtc_cal_pkg::*;
#(
  parameter int unsigned CENTURY = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic load,
  input  cal_t load_val,
  output cal_t cur
);

  cal_t nxt;

  always_comb nxt = next_sec(cur, CENTURY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '{yr: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd0,
               hr: 5'd0, min: 6'd0, sec: 6'd0};
    end else if (load) begin
      cur <= load_val;
    end else if (adv) begin
      cur <= nxt;
    end
  end

  // R6: seconds wrap and carry into minutes
  a_r6_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load && cur.sec == 6'd59 |=> cur.sec == 6'd0);
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !load |=> $stable(cur));

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
  parameter int unsigned DELAY_US = 244
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ok,
  input  logic us_tick,
  input  logic set_mode,
  input  logic cancel,
  output logic start,
  output logic done,
  output logic busy,
  output logic uip
);

  localparam int unsigned CW = $clog2(DELAY_US + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_US - 1);

  logic [CW-1:0] cnt;

  assign start = tick_ok && !busy && !cancel;
  assign done  = busy && us_tick && (cnt == LAST) && !cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      uip  <= 1'b0;
    end else if (cancel) begin
      busy <= 1'b0;
      cnt  <= '0;
      uip  <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
      uip  <= !set_mode;
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
      uip  <= 1'b0;
    end else begin
      if (busy && us_tick) cnt <= cnt + 1'b1;
      if (set_mode) uip <= 1'b0;
    end
  end

  // R2: update bit only inside an update window
  a_r2_uip_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    uip |-> busy);
  // R2: window closes exactly when the copy happens
  a_r2_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !uip);
  // R11: cancel abandons the window
  a_r11_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !busy && !uip);
  // R3: set mode never raises the update bit
  a_r3_no_uip: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode && !uip |=> !uip);

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
(
  input  cal_t       cur,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hr,
  input  logic       bin,
  input  logic       h24,
  output logic       hit
);

  logic       s_ok, m_ok, h_ok;
  logic [6:0] s_v, m_v;
  logic [4:0] h_v;

  always_comb begin
    s_v  = dec_val(alm_sec, bin);
    m_v  = dec_val(alm_min, bin);
    h_v  = dec_hour(alm_hr, bin, h24);
    s_ok = (alm_sec[7:6] == 2'b11) || (s_v == {1'b0, cur.sec});
    m_ok = (alm_min[7:6] == 2'b11) || (m_v == {1'b0, cur.min});
    h_ok = (alm_hr[7:6] == 2'b11)  || (h_v == cur.hr);
    hit  = s_ok && m_ok && h_ok;
  end

endmodule

// File: rtl/rtc_calendar_engine.sv
module rtc_calendar_engine
  import rtc_cal_pkg::*;
#(
  parameter int unsigned DELAY_US = 244,
  parameter int unsigned CENTURY  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       us_tick,
  input  logic [2:0] osc_sel,
  input  logic       set_mode,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic       alarm_en,
  input  logic       uend_en,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hr,
  input  logic       load_en,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hr,
  input  logic [7:0] ld_wday,
  input  logic [7:0] ld_mday,
  input  logic [7:0] ld_mon,
  input  logic [7:0] ld_year,
  input  logic       flag_clr,
  output logic [7:0] out_sec,
  output logic [7:0] out_min,
  output logic [7:0] out_hr,
  output logic [7:0] out_wday,
  output logic [7:0] out_mday,
  output logic [7:0] out_mon,
  output logic [7:0] out_year,
  output logic       uip,
  output logic [7:0] flags
);

  // named internal events
  logic tick_ok, step, copy_done, upd_busy, alarm_hit, set_af, set_uf;
  cal_t cur, ld_cal;
  vis_t ld_raw, ld_show, cur_show, vis;

  assign tick_ok = sec_tick && (osc_sel == OSC_RUN);

  always_comb begin
    ld_raw   = '{yr: ld_year, mon: ld_mon, mday: ld_mday, wday: ld_wday,
                 hr: ld_hr, min: ld_min, sec: ld_sec};
    ld_cal   = dec_cal(ld_raw, bin_mode, hr24);
    ld_show  = fmt_cal(ld_cal, bin_mode, hr24);
    cur_show = fmt_cal(cur, bin_mode, hr24);
  end

  rtc_update_seq #(.DELAY_US(DELAY_US)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_ok  (tick_ok),
    .us_tick  (us_tick),
    .set_mode (set_mode),
    .cancel   (load_en),
    .start    (step),
    .done     (copy_done),
    .busy     (upd_busy),
    .uip      (uip)
  );

  rtc_cal_counter #(.CENTURY(CENTURY)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (step),
    .load     (load_en),
    .load_val (ld_cal),
    .cur      (cur)
  );

  rtc_alarm_match u_alm (
    .cur     (cur),
    .alm_sec (alm_sec),
    .alm_min (alm_min),
    .alm_hr  (alm_hr),
    .bin     (bin_mode),
    .h24     (hr24),
    .hit     (alarm_hit)
  );

  assign set_af = copy_done && alarm_en && alarm_hit;
  assign set_uf = copy_done && uend_en && !set_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis <= '{yr: 8'h00, mon: 8'h01, mday: 8'h01, wday: 8'h00,
               hr: 8'h00, min: 8'h00, sec: 8'h00};
    end else if (load_en) begin
      vis <= ld_show;
    end else if (copy_done && !set_mode) begin
      vis <= cur_show;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= 8'h00;
    end else begin
      flags <= (flag_clr ? 8'h00 : flags)
             | (set_af ? FLG_ALARM : 8'h00)
             | (set_uf ? FLG_UEND : 8'h00);
    end
  end

  assign out_sec  = vis.sec;
  assign out_min  = vis.min;
  assign out_hr   = vis.hr;
  assign out_wday = vis.wday;
  assign out_mday = vis.mday;
  assign out_mon  = vis.mon;
  assign out_year = vis.yr;

  // R1: a tick with the oscillator stopped raises nothing
  a_r1_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && osc_sel != 3'b010 && !load_en && !upd_busy |=> !uip);
  // R3: set mode freezes the visible registers at copy time
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done && set_mode && !load_en |=> $stable(out_sec) && $stable(out_hr)
                                          && $stable(out_mday));
  // R9: update-ended flag rises only from a completed update
  a_r9_uf_source: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[4] && !(copy_done && uend_en && !set_mode) |=> !flags[4]);
  // R8: alarm flag needs the enable
  a_r8_af_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[5] && !alarm_en |=> !flags[5]);
  // R10: clear empties the flags when nothing new arrives
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !copy_done |=> flags == 8'h00);

endmodule

// File: tb/rtc_calendar_engine_test.sv
module rtc_calendar_engine_test;

  localparam int DLY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 0, us_tick = 1, set_mode = 0, bin_mode = 0, hr24 = 1;
  logic alarm_en = 0, uend_en = 0, load_en = 0, flag_clr = 0;
  logic [2:0] osc_sel = 3'b010;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hr = 0;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hr = 0, ld_wday = 0, ld_mday = 1, ld_mon = 1, ld_year = 0;
  logic [7:0] out_sec, out_min, out_hr, out_wday, out_mday, out_mon, out_year, flags;
  logic uip;

  int n_chk = 0, n_bad = 0;
  int ms, mm, mh, mw, md, mo, my;

  always #4 clk = ~clk;

  rtc_calendar_engine #(.DELAY_US(DLY), .CENTURY(20)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .us_tick(us_tick), .osc_sel(osc_sel),
    .set_mode(set_mode), .bin_mode(bin_mode), .hr24(hr24), .alarm_en(alarm_en),
    .uend_en(uend_en), .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
    .load_en(load_en), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hr(ld_hr), .ld_wday(ld_wday),
    .ld_mday(ld_mday), .ld_mon(ld_mon), .ld_year(ld_year), .flag_clr(flag_clr),
    .out_sec(out_sec), .out_min(out_min), .out_hr(out_hr), .out_wday(out_wday),
    .out_mday(out_mday), .out_mon(out_mon), .out_year(out_year), .uip(uip), .flags(flags));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int fv(input int v);
    return bin_mode ? v : v + 6 * (v / 10);
  endfunction

  function automatic int fh(input int h);
    int hh;
    if (hr24) return fv(h);
    hh = h % 12;
    if (hh == 0) hh = 12;
    return fv(hh) + ((h >= 12) ? 128 : 0);
  endfunction

  function automatic int mlen(input int m, input int yy);
    int full;
    full = 2000 + yy;
    if (m == 2) return (((full % 4) == 0 && (full % 100) != 0) || (full % 400) == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    ms++;
    if (ms < 60) return;
    ms = 0; mm++;
    if (mm < 60) return;
    mm = 0; mh++;
    if (mh < 24) return;
    mh = 0; mw = (mw + 1) % 7; md++;
    if (md <= mlen(mo, my)) return;
    md = 1; mo++;
    if (mo <= 12) return;
    mo = 1; my = (my + 1) % 100;
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " sec"},  out_sec,  fv(ms));
    chk({tag, " min"},  out_min,  fv(mm));
    chk({tag, " hr"},   out_hr,   fh(mh));
    chk({tag, " wday"}, out_wday, fv(mw));
    chk({tag, " mday"}, out_mday, fv(md));
    chk({tag, " mon"},  out_mon,  fv(mo));
    chk({tag, " year"}, out_year, fv(my));
  endtask

  task automatic set_model(input int y, input int m, input int d, input int w,
                           input int h, input int mi, input int s);
    my = y; mo = m; md = d; mw = w; mh = h; mm = mi; ms = s;
  endtask

  task automatic do_load();
    @(negedge clk);
    ld_sec = 8'(fv(ms)); ld_min = 8'(fv(mm)); ld_hr = 8'(fh(mh)); ld_wday = 8'(fv(mw));
    ld_mday = 8'(fv(md)); ld_mon = 8'(fv(mo)); ld_year = 8'(fv(my));
    load_en = 1;
    @(negedge clk);
    load_en = 0;
  endtask

  // tick, check uip one edge later, wait for the copy
  task automatic do_tick(input string tag, input logic exp_uip);
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    chk({tag, " uip"}, uip, exp_uip);
    repeat (DLY + 2) @(negedge clk);
    chk({tag, " uip end"}, uip, 0);
  endtask

  task automatic clear_flags();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    set_model(0, 1, 1, 0, 0, 0, 0);
    chk_regs("R12 reset");
    chk("R12 uip", uip, 0);
    chk("R12 flags", flags, 0);

    // R2 basic update, R4 BCD, R6 minute carry
    set_model(24, 6, 15, 2, 10, 20, 59);
    do_load();
    chk_regs("R11 load");
    do_tick("R2 tick", 1);
    model_step();
    chk_regs("R2 R6 update");

    // R5 hour sweep, 12-hour BCD
    hr24 = 0;
    for (int h = 0; h < 24; h++) begin
      set_model(24, 6, 15, 2, h, 59, 59);
      do_load();
      chk("R5 load hr", out_hr, fh(h));
      do_tick("R5 tick", 1);
      model_step();
      chk("R5 next hr", out_hr, fh(mh));
      chk("R6 mday", out_mday, fv(md));
    end
    hr24 = 1;

    // R4 binary, R6 month ends and year wrap
    bin_mode = 1;
    for (int m = 1; m <= 12; m++) begin
      set_model((m == 12) ? 99 : 23, m, mlen(m, 23), 6, 23, 59, 59);
      do_load();
      do_tick("R6 month end", 1);
      model_step();
      chk_regs("R4 R6 month end");
    end
    // R7 leap cases
    set_model(24, 2, 28, 1, 23, 59, 59); do_load(); do_tick("R7", 1); model_step();
    chk_regs("R7 2024 feb28");
    set_model(24, 2, 29, 1, 23, 59, 59); do_load(); do_tick("R7", 1); model_step();
    chk_regs("R7 2024 feb29");
    set_model(23, 2, 28, 1, 23, 59, 59); do_load(); do_tick("R7", 1); model_step();
    chk_regs("R7 2023 feb28");
    set_model(0, 2, 28, 1, 23, 59, 59); do_load(); do_tick("R7", 1); model_step();
    chk_regs("R7 2000 feb28");
    bin_mode = 0;

    // R1 divider off
    set_model(24, 6, 15, 2, 1, 2, 3);
    do_load();
    osc_sel = 3'b000;
    do_tick("R1 stopped", 0);
    chk_regs("R1 stopped");
    osc_sel = 3'b010;
    do_tick("R1 running", 1);
    model_step();
    chk_regs("R1 running");

    // R3 set mode
    uend_en = 1;
    clear_flags();
    set_mode = 1;
    do_tick("R3 set", 0);
    chk("R3 frozen sec", out_sec, 8'h04);
    chk("R3 no uf", flags, 0);
    set_mode = 0;
    do_tick("R3 resume", 1);
    model_step(); model_step();
    chk_regs("R3 resume");
    // R9 update-ended flag
    chk("R9 uf", flags, 8'h90);
    clear_flags();
    chk("R10 clear", flags, 0);
    uend_en = 0;

    // R8 alarm
    alarm_en = 1;
    set_model(24, 6, 15, 2, 10, 20, 29);
    do_load();
    alm_sec = 8'h30; alm_min = 8'h20; alm_hr = 8'h10;
    do_tick("R8 exact", 1);
    chk("R8 exact match", flags, 8'ha0);
    clear_flags();
    alm_sec = 8'hC0; alm_min = 8'hFF; alm_hr = 8'h10;
    do_tick("R8 wild", 1);
    chk("R8 wildcard match", flags, 8'ha0);
    clear_flags();
    alm_hr = 8'h11;
    do_tick("R8 miss", 1);
    chk("R8 hour mismatch", flags, 0);
    // R8 hour alarm in 12-hour form: 10 AM
    hr24 = 0; alm_hr = 8'h10;
    do_tick("R8 12h", 1);
    chk("R8 12h match", flags, 8'ha0);
    hr24 = 1;
    // R9 + R8 together, then R10 set-wins (clear during copy)
    uend_en = 1;
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    repeat (DLY - 1) @(negedge clk);
    flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk("R10 set wins over clear", flags, 8'hb0);
    repeat (2) @(negedge clk);
    alarm_en = 0; uend_en = 0;
    clear_flags();

    // R11 load cancels update in flight
    set_model(24, 6, 15, 2, 5, 5, 5);
    do_load();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    chk("R11 uip before load", uip, 1);
    set_model(24, 6, 15, 2, 8, 8, 8);
    do_load();
    chk("R11 uip cleared", uip, 0);
    repeat (DLY + 2) @(negedge clk);
    chk_regs("R11 no late copy");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule